// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor Core

This block is a small processor that keeps program and data storage apart. The program memory is read-only, with 8-bit instruction words and up to 16 of them. The data storage is an internal RAM of 16 words, 4 bits each. Each instruction word carries a 4-bit opcode in bits [7:4] and a 4-bit constant in bits [3:0]. The core has three state registers: a 4-bit program counter, a 4-bit accumulator and a 4-bit address register. Every data RAM access is addressed through the address register. Every instruction completes in one clock cycle.

Bit 0 of the opcode selects the operand of each instruction. When it is 0 the operand is the constant field. When it is 1 the operand is the RAM word at the address held in the address register. The opcodes cover the following groups:

- load, add and subtract;
- store and double-indirect store;
- set-address;
- unconditional jump and jump-if-zero;
- two spare codes that do nothing except advance the program counter.

The program memory is external and synchronous, so the core presents the address of the *next* instruction on `prog_addr_o`. The memory registers the word at that address on the same edge that updates the program counter. The write strobe, write address and write data of the data RAM are brought out so that stores can be observed.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, accumulator and address register to 0 and clears every data RAM word to 0. While reset is high, `prog_addr_o` is 0.
- R2: Opcode bit 0 selects the operand: 0 selects the constant field (instruction bits [3:0]), 1 selects the data RAM word at the address register.
- R3: Opcodes 0000 and 0001 load the operand into the accumulator.
- R4: Opcodes 0010 and 0011 set the accumulator to accumulator plus operand, modulo 16.
- R5: Opcodes 0100 and 0101 set the accumulator to accumulator minus operand, modulo 16.
- R6: Opcode 0110 writes the accumulator to the RAM word at the address register. The accumulator and the address register do not change.
- R7: Opcode 0111 writes the accumulator to the RAM word whose address is the value stored in RAM at the address register. The word at the address register itself is not changed.
- R8: Opcodes 1000 and 1001 load the operand into the address register and leave the accumulator unchanged.
- R9: Opcodes 1010 and 1011 load the operand into the program counter.
- R10: Opcodes 1100 and 1101 load the operand into the program counter when the accumulator is 0, and otherwise increment the program counter.
- R11: Every opcode other than 1010 to 1101 increments the program counter by one, wrapping from 15 to 0.
- R12: Opcodes 1110 and 1111 change neither the accumulator, the address register nor the data RAM.
- R13: `mem_we_o` is high only during opcodes 0110 and 0111. A stored value is visible to the next instruction that reads that RAM word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 8 | Instruction word from the program memory for the current program counter |
| prog_addr_o | output | 4 | Program memory address of the next instruction (0 while in reset) |
| pc_o | output | 4 | Current program counter |
| acc_o | output | 4 | Current accumulator |
| addr_o | output | 4 | Current address register |
| mem_we_o | output | 1 | Data RAM write strobe for the current instruction |
| mem_waddr_o | output | 4 | Data RAM write address for the current instruction |
| mem_wdata_o | output | 4 | Data RAM write data for the current instruction |

## Verification
The assertions check the following rules on every cycle:

- Spare opcodes, stores and set-address instructions leave the program counter one step further on.
- A jump lands on its operand.
- A jump-if-zero with a non-zero accumulator falls through.
- The accumulator holds across instructions that do not write it.
- The write strobe rises only for store opcodes.
- A RAM write always lands in the addressed word.
- The first cycle after reset shows cleared registers.
- Subtraction always inverts addition.

Only the bench scenarios can show the following:

- the arithmetic values that come out of mixed constant and memory operands;
- the double-indirect store target, and that the pointer word is left untouched;
- that the RAM really reads back as zero after a reset;
- that taken and not-taken branches, including memory-operand jumps and the 15-to-0 wrap, follow a whole program.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_LD_K   = 4'h0,
        OPC_LD_M   = 4'h1,
        OPC_ADD_K  = 4'h2,
        OPC_ADD_M  = 4'h3,
        OPC_SUB_K  = 4'h4,
        OPC_SUB_M  = 4'h5,
        OPC_ST     = 4'h6,
        OPC_ST_IND = 4'h7,
        OPC_PTR_K  = 4'h8,
        OPC_PTR_M  = 4'h9,
        OPC_JMP_K  = 4'hA,
        OPC_JMP_M  = 4'hB,
        OPC_JZ_K   = 4'hC,
        OPC_JZ_M   = 4'hD,
        OPC_SPARE0 = 4'hE,
        OPC_SPARE1 = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_op_e;

    typedef enum logic [1:0] {
        PC_STEP   = 2'd0,
        PC_TARGET = 2'd1,
        PC_IFZERO = 2'd2
    } pc_sel_e;

    typedef struct packed {
        logic    use_mem;
        logic    acc_we;
        logic    ptr_we;
        logic    mem_we;
        logic    mem_ind;
        alu_op_e alu_op;
        pc_sel_e pc_sel;
    } ctrl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_core_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output ctrl_t            ctrl_o
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d         = '0;
        ctrl_d.use_mem = opcode_i[0];
        ctrl_d.alu_op  = ALU_PASS;
        ctrl_d.pc_sel  = PC_STEP;
        case (opcode_e'(opcode_i))
            OPC_LD_K, OPC_LD_M: begin
                ctrl_d.acc_we = 1'b1;
                ctrl_d.alu_op = ALU_PASS;
            end
            OPC_ADD_K, OPC_ADD_M: begin
                ctrl_d.acc_we = 1'b1;
                ctrl_d.alu_op = ALU_ADD;
            end
            OPC_SUB_K, OPC_SUB_M: begin
                ctrl_d.acc_we = 1'b1;
                ctrl_d.alu_op = ALU_SUB;
            end
            OPC_ST: begin
                ctrl_d.mem_we  = 1'b1;
                ctrl_d.mem_ind = 1'b0;
            end
            OPC_ST_IND: begin
                ctrl_d.mem_we  = 1'b1;
                ctrl_d.mem_ind = 1'b1;
            end
            OPC_PTR_K, OPC_PTR_M: begin
                ctrl_d.ptr_we = 1'b1;
            end
            OPC_JMP_K, OPC_JMP_M: begin
                ctrl_d.pc_sel = PC_TARGET;
            end
            OPC_JZ_K, OPC_JZ_M: begin
                ctrl_d.pc_sel = PC_IFZERO;
            end
            default: begin
                ctrl_d.pc_sel = PC_STEP;
            end
        endcase
    end

    assign ctrl_o = ctrl_d;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    input  alu_op_e       op_i,
    output logic [DW-1:0] res_o
);

    logic [DW-1:0] res_d;
    logic [DW-1:0] back_d;

    always_comb begin
        case (op_i)
            ALU_ADD: res_d = acc_i + opnd_i;
            ALU_SUB: res_d = acc_i - opnd_i;
            default: res_d = opnd_i;
        endcase
    end

    assign res_o  = res_d;
    assign back_d = res_d + opnd_i;

    always_comb begin
        if (op_i == ALU_SUB && !$isunknown({acc_i, opnd_i})) begin
            AST_SUB_INVERTS_ADD: assert (back_d == acc_i); // R5
        end
    end

endmodule

// File: rtl/acc_dataram.sv
module acc_dataram #(
    parameter int DW = 4,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    AST_RAM_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i))); // R13

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W+DW-1:0] instr_i,
    output logic [DW-1:0]     prog_addr_o,
    output logic [DW-1:0]     pc_o,
    output logic [DW-1:0]     acc_o,
    output logic [DW-1:0]     addr_o,
    output logic              mem_we_o,
    output logic [DW-1:0]     mem_waddr_o,
    output logic [DW-1:0]     mem_wdata_o
);

    localparam int IW = OPC_W + DW;
    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] acc;
        logic [DW-1:0] addr;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [OPC_W-1:0] opcode;
    logic [DW-1:0]    imm;
    ctrl_t            ctrl;
    logic [DW-1:0]    ram_rd;
    logic [DW-1:0]    operand;
    logic [DW-1:0]    alu_res;
    logic [DW-1:0]    pc_step;
    logic             wr_en;
    logic [DW-1:0]    wr_addr;

    assign opcode = instr_i[IW-1 -: OPC_W];
    assign imm    = instr_i[DW-1:0];

    acc_decode u_decode (
        .opcode_i (opcode),
        .ctrl_o   (ctrl)
    );

    acc_dataram #(.DW(DW), .AW(DW)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .raddr_i (st_q.addr),
        .rdata_o (ram_rd),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wdata_i (st_q.acc)
    );

    assign operand = ctrl.use_mem ? ram_rd : imm;

    acc_alu #(.DW(DW)) u_alu (
        .acc_i  (st_q.acc),
        .opnd_i (operand),
        .op_i   (ctrl.alu_op),
        .res_o  (alu_res)
    );

    assign pc_step = st_q.pc + ONE;
    assign wr_en   = ctrl.mem_we & ~rst;
    assign wr_addr = ctrl.mem_ind ? ram_rd : st_q.addr;

    always_comb begin
        st_d = st_q;
        if (ctrl.acc_we) begin
            st_d.acc = alu_res;
        end
        if (ctrl.ptr_we) begin
            st_d.addr = operand;
        end
        case (ctrl.pc_sel)
            PC_TARGET: st_d.pc = operand;
            PC_IFZERO: st_d.pc = (st_q.acc == '0) ? operand : pc_step;
            default:   st_d.pc = pc_step;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_addr_o = rst ? '0 : st_d.pc;
    assign pc_o        = st_q.pc;
    assign acc_o       = st_q.acc;
    assign addr_o      = st_q.addr;
    assign mem_we_o    = wr_en;
    assign mem_waddr_o = wr_addr;
    assign mem_wdata_o = st_q.acc;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st_q == '0)); // R1

    AST_STEP_PC: assert property (@(posedge clk) disable iff (rst)
        (opcode[3:1] != 3'b101 && opcode[3:1] != 3'b110)
        |=> (st_q.pc == $past(st_q.pc) + ONE)); // R11

    AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (rst)
        (opcode[3:1] == 3'b101) |=> (st_q.pc == $past(operand))); // R9

    AST_JZ_FALLS: assert property (@(posedge clk) disable iff (rst)
        (opcode[3:1] == 3'b110 && st_q.acc != '0)
        |=> (st_q.pc == $past(st_q.pc) + ONE)); // R10

    AST_ACC_HELD: assert property (@(posedge clk) disable iff (rst)
        (opcode[3] == 1'b1 || opcode[3:1] == 3'b011) |=> $stable(st_q.acc)); // R8

    AST_PTR_HELD: assert property (@(posedge clk) disable iff (rst)
        (opcode[3:1] != 3'b100) |=> $stable(st_q.addr)); // R12

    AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (instr_i[IW-1 -: 3] == 3'b011)); // R13

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] instr;
    logic [3:0] prog_addr, pc, acc, addr, waddr, wdata;
    logic       we;
    logic [7:0] rom [16];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) instr <= rom[prog_addr];

    acc_core dut (
        .clk (clk), .rst (rst), .instr_i (instr), .prog_addr_o (prog_addr),
        .pc_o (pc), .acc_o (acc), .addr_o (addr),
        .mem_we_o (we), .mem_waddr_o (waddr), .mem_wdata_o (wdata)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 16; i++) rom[i] = 8'hE0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_arith();
        clear_rom();
        rom[0] = 8'h05; rom[1] = 8'h2C; rom[2] = 8'h43;
        do_reset();
        chk("R1", "pc after reset", pc, 0);
        step(1); chk("R3", "load const", acc, 5);
        step(1); chk("R4", "add const wraps", acc, 1);
        chk("R11", "pc after two steps", pc, 2);
        step(1); chk("R5", "sub const wraps", acc, 14);
    endtask

    task automatic t_store();
        clear_rom();
        rom[0] = 8'h83; rom[1] = 8'h09; rom[2] = 8'h60; rom[3] = 8'h00;
        rom[4] = 8'h10; rom[5] = 8'h30; rom[6] = 8'h50; rom[7] = 8'h90;
        do_reset();
        chk("R1", "acc after reset", acc, 0);
        step(1); chk("R8", "set-address const", addr, 3);
        chk("R8", "acc kept by set-address", acc, 0);
        step(1);
        chk("R6", "store strobe", we, 1);
        chk("R6", "store address", waddr, 3);
        chk("R6", "store data", wdata, 9);
        step(1); chk("R6", "acc kept by store", acc, 9);
        chk("R6", "addr kept by store", addr, 3);
        chk("R13", "strobe low on load", we, 0);
        step(2); chk("R2", "load memory operand", acc, 9);
        step(1); chk("R4", "add memory operand", acc, 2);
        step(1); chk("R5", "sub memory operand", acc, 9);
        step(1); chk("R8", "set-address memory", addr, 9);
    endtask

    task automatic t_reset_ram();
        clear_rom();
        rom[0] = 8'h83; rom[1] = 8'h10;
        do_reset();
        chk("R1", "addr after reset", addr, 0);
        step(2); chk("R1", "ram cleared by reset", acc, 0);
    endtask

    task automatic t_indirect();
        clear_rom();
        rom[0] = 8'h84; rom[1] = 8'h07; rom[2] = 8'h60; rom[3] = 8'h0B;
        rom[4] = 8'h70; rom[5] = 8'h87; rom[6] = 8'h10; rom[7] = 8'h84;
        rom[8] = 8'h10;
        do_reset();
        step(4);
        chk("R7", "indirect store strobe", we, 1);
        chk("R7", "indirect store address", waddr, 7);
        step(3); chk("R7", "indirect target holds value", acc, 11);
        step(2); chk("R7", "pointer word unchanged", acc, 7);
    endtask

    task automatic t_jumps();
        clear_rom();
        rom[0] = 8'hA5;
        for (int i = 1; i < 5; i++) rom[i] = 8'h0F;
        rom[5] = 8'h00; rom[6] = 8'hC9; rom[7] = 8'h0F; rom[8] = 8'h0F;
        rom[9] = 8'h03; rom[10] = 8'hC0; rom[11] = 8'h0E; rom[12] = 8'h60;
        rom[13] = 8'hB0; rom[14] = 8'hE0; rom[15] = 8'hF7;
        do_reset();
        step(1); chk("R9", "jump const", pc, 5);
        step(2); chk("R10", "jz taken", pc, 9);
        step(2); chk("R10", "jz not taken", pc, 11);
        step(3); chk("R9", "jump memory", pc, 14);
        chk("R13", "strobe low on spare", we, 0);
        step(1); chk("R12", "spare keeps acc", acc, 14);
        step(1); chk("R11", "pc wraps 15 to 0", pc, 0);
        chk("R12", "spare keeps addr", addr, 0);
        chk("R12", "spare keeps acc again", acc, 14);
    endtask

    task automatic t_jz_mem();
        clear_rom();
        rom[0] = 8'h06; rom[1] = 8'h85; rom[2] = 8'h60; rom[3] = 8'h00;
        rom[4] = 8'hD0; rom[5] = 8'h0F; rom[6] = 8'h01; rom[7] = 8'hD0;
        do_reset();
        step(5); chk("R10", "jz memory taken", pc, 6);
        chk("R10", "skipped word not run", acc, 0);
        step(2); chk("R10", "jz memory not taken", pc, 8);
    endtask

    initial begin
        clear_rom();
        do_reset();
        t_arith();
        t_store();
        t_reset_ram();
        t_indirect();
        t_jumps();
        t_jz_mem();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule